// File: doc/BRIEF.md
# Multi-Plane Page Program Sequencer

This block sits on the host side of a NAND flash bus. It writes up to four pages in one operation, one page per plane. A request carries a four-bit plane mask, one block number per plane, a page number and a flag for the second-half pointer mode. The sequencer first checks the request. For each selected plane, in ascending order, it then issues the load command, the column and row address cycles, and one page of data drawn from a byte stream. Each plane except the last is closed with the dummy-program command. The last plane is closed with the true program command.

After every close command the sequencer waits a short fixed time, then waits for the device's ready line. When the final program has finished, it issues the multi-plane status command and reads one status byte. It reports the per-plane fail bits and the summary fail bit with a one-cycle done pulse. A request that cannot be carried out is answered with a reject pulse, and no bus cycle is issued for it.

Top module: `mp_prog_seq`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `s_ready`, `bus_we`, `bus_re` and `done` are 0. `req_ready` is 1 only while idle, and is never 1 together with `s_ready`.
- R2: A request is rejected in any of three cases: its mask is zero, an active plane p has a block whose two low bits differ from p, or `req_ptr_b` is 1. A rejected request gives `done`=1 and `done_reject`=1 one cycle after acceptance, with `done_fail`=0 and `done_any_fail`=0, and issues no bus cycle.
- R3: The active planes are served in ascending index order. Each plane gets command 0x80 (`bus_cle`), then four address cycles (`bus_ale`): column byte 0x00, then the row bytes least significant first. The row is block·2^PAGE_W + page.
- R4: `s_ready` is 1 only during a data phase. Each accepted stream byte appears as a data write on the bus (`bus_we`=1, `bus_cle`=`bus_ale`=0) in the next cycle. Exactly PAGE_BYTES (default 528) bytes are taken per active plane.
- R5: Each active plane except the highest-indexed one is closed with command 0x11. The highest active plane is closed with 0x10.
- R6: After a close command, no further bus cycle is issued until `dev_rdy` has been seen high, and that check starts only after WB_CYC cycles.
- R7: Once the device is ready after the 0x10 close, the block issues command 0x71. A single read strobe `bus_re` follows in the next cycle.
- R8: `done` pulses one cycle after the read strobe. `done_fail[p]` is status bit p+1 of the byte read, `done_any_fail` is status bit 0, and `done_reject` is 0.
- R9: `bus_cle` and `bus_ale` are never both 1. Either one is 1 only together with `bus_we`, and `bus_re` is never 1 together with `bus_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block is idle and takes a request |
| req_mask | input | NPL | Active-plane mask |
| req_blocks | input | NPL*BLK_W | Block number per plane, plane 0 in the low bits |
| req_page | input | PAGE_W | Page within each block |
| req_ptr_b | input | 1 | Second-half pointer mode requested (always rejected) |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Stream byte taken this cycle if valid |
| bus_cle | output | 1 | Command latch enable |
| bus_ale | output | 1 | Address latch enable |
| bus_we | output | 1 | Write strobe for the current bus cycle |
| bus_re | output | 1 | Read strobe for the status byte |
| bus_dout | output | 8 | Bus write byte |
| bus_din | input | 8 | Bus read byte, sampled while `bus_re` is 1 |
| dev_rdy | input | 1 | Device ready line (1 = ready) |
| done | output | 1 | One-cycle completion pulse |
| done_reject | output | 1 | Request was rejected (valid with `done`) |
| done_fail | output | NPL | Per-plane fail bits (valid with `done`) |
| done_any_fail | output | 1 | Summary fail bit (valid with `done`) |

## Verification
Bus items are checked for order rather than for absolute cycle. A data write is due in the cycle after its stream handshake, and the read strobe is due in the cycle after the 0x71 command. A result is due one cycle after the read strobe, or one cycle after the request for a reject. The bench queues the expected bus items and results when it issues a request. A monitor samples on the falling edge, and pops and compares an item whenever a strobe or `done` is seen, so waits of any length are tolerated. The device model holds `dev_rdy` low after each close command, and the monitor flags any bus cycle issued while the device is busy.

// File: rtl/mp_seq_pkg.sv
package mp_seq_pkg;

    localparam logic [7:0] CMD_LOAD  = 8'h80;
    localparam logic [7:0] CMD_DUMMY = 8'h11;
    localparam logic [7:0] CMD_PROG  = 8'h10;
    localparam logic [7:0] CMD_MSTAT = 8'h71;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LOAD_CMD,
        S_ADDR,
        S_DATA,
        S_CLOSE,
        S_WB,
        S_BUSY,
        S_ST_CMD,
        S_ST_RD,
        S_ST_CAP
    } seq_state_e;

endpackage

// File: rtl/mp_plane_pick.sv
// Finds the lowest active plane, either overall (from_start) or above cur.
module mp_plane_pick #(
    parameter int NPL  = 4,
    parameter int PL_W = 2
) (
    input  logic [NPL-1:0]  mask,
    input  logic [PL_W-1:0] cur,
    input  logic            from_start,
    output logic [PL_W-1:0] sel,
    output logic            found
);
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = NPL - 1; i >= 0; i--) begin
            if (mask[i] && (from_start || i > int'(cur))) begin
                sel   = PL_W'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mp_req_check.sv
// Each active plane's block must sit in that plane; pointer-B mode is refused.
module mp_req_check #(
    parameter int NPL   = 4,
    parameter int BLK_W = 12,
    parameter int PL_W  = 2
) (
    input  logic [NPL-1:0]       mask,
    input  logic [NPL*BLK_W-1:0] blocks,
    input  logic                 ptr_b,
    output logic                 ok
);
    logic [NPL-1:0] match;

    for (genvar p = 0; p < NPL; p++) begin : g_plane
        assign match[p] = !mask[p] || (blocks[p*BLK_W +: PL_W] == PL_W'(p));
    end

    assign ok = (&match) && !ptr_b;
endmodule

// File: rtl/mp_prog_seq.sv
module mp_prog_seq
    import mp_seq_pkg::*;
#(
    parameter int NPL        = 4,
    parameter int PAGE_BYTES = 528,
    parameter int BLK_W      = 12,
    parameter int PAGE_W     = 5,
    parameter int ROW_BYTES  = 3,
    parameter int WB_CYC     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [NPL-1:0]       req_mask,
    input  logic [NPL*BLK_W-1:0] req_blocks,
    input  logic [PAGE_W-1:0]    req_page,
    input  logic                 req_ptr_b,
    input  logic                 s_valid,
    input  logic [7:0]           s_data,
    output logic                 s_ready,
    output logic                 bus_cle,
    output logic                 bus_ale,
    output logic                 bus_we,
    output logic                 bus_re,
    output logic [7:0]           bus_dout,
    input  logic [7:0]           bus_din,
    input  logic                 dev_rdy,
    output logic                 done,
    output logic                 done_reject,
    output logic [NPL-1:0]       done_fail,
    output logic                 done_any_fail
);
    localparam int PL_W  = (NPL > 1) ? $clog2(NPL) : 1;
    localparam int ACYC  = 1 + ROW_BYTES;
    localparam int ROW_W = BLK_W + PAGE_W;
    localparam int CNT_W = $clog2(PAGE_BYTES + ACYC + WB_CYC + 1);

    typedef struct packed {
        seq_state_e           st;
        logic [NPL-1:0]       mask;
        logic [NPL*BLK_W-1:0] blks;
        logic [PAGE_W-1:0]    page;
        logic [PL_W-1:0]      cur;
        logic [CNT_W-1:0]     cnt;
        logic                 cle;
        logic                 ale;
        logic                 we;
        logic                 re;
        logic [7:0]           dout;
        logic                 done;
        logic                 rej;
        logic [NPL-1:0]       fail;
        logic                 anyf;
    } regs_t;

    regs_t q, d;

    logic                 req_ok;
    logic [PL_W-1:0]      first_pl;
    logic                 first_found;
    logic [PL_W-1:0]      next_pl;
    logic                 next_found;
    logic [BLK_W-1:0]     cur_blk;
    logic [ROW_BYTES*8-1:0] row_ext;
    logic [7:0]           addr_byte;

    mp_req_check #(.NPL(NPL), .BLK_W(BLK_W), .PL_W(PL_W)) req_chk_i (
        .mask   (req_mask),
        .blocks (req_blocks),
        .ptr_b  (req_ptr_b),
        .ok     (req_ok)
    );

    mp_plane_pick #(.NPL(NPL), .PL_W(PL_W)) pick_first_i (
        .mask       (req_mask),
        .cur        ('0),
        .from_start (1'b1),
        .sel        (first_pl),
        .found      (first_found)
    );

    mp_plane_pick #(.NPL(NPL), .PL_W(PL_W)) pick_next_i (
        .mask       (q.mask),
        .cur        (q.cur),
        .from_start (1'b0),
        .sel        (next_pl),
        .found      (next_found)
    );

    // Row address: block above page, zero-padded to whole bytes.
    always_comb begin
        cur_blk = q.blks[q.cur*BLK_W +: BLK_W];
        row_ext = '0;
        row_ext[ROW_W-1:0] = {cur_blk, q.page};
        addr_byte = 8'h00;
        for (int b = 0; b < ROW_BYTES; b++) begin
            if (int'(q.cnt) == b + 1) addr_byte = row_ext[b*8 +: 8];
        end
    end

    assign req_ready = (q.st == S_IDLE);
    assign s_ready   = (q.st == S_DATA);

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        d.cle  = 1'b0;
        d.ale  = 1'b0;
        d.re   = 1'b0;
        d.done = 1'b0;
        d.rej  = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.mask = req_mask;
                    d.blks = req_blocks;
                    d.page = req_page;
                    d.fail = '0;
                    d.anyf = 1'b0;
                    if (req_ok && first_found) begin
                        d.cur = first_pl;
                        d.st  = S_LOAD_CMD;
                    end else begin
                        d.done = 1'b1;
                        d.rej  = 1'b1;
                    end
                end
            end
            S_LOAD_CMD: begin
                d.we   = 1'b1;
                d.cle  = 1'b1;
                d.dout = CMD_LOAD;
                d.cnt  = '0;
                d.st   = S_ADDR;
            end
            S_ADDR: begin
                d.we   = 1'b1;
                d.ale  = 1'b1;
                d.dout = addr_byte;
                if (int'(q.cnt) == ACYC - 1) begin
                    d.cnt = '0;
                    d.st  = S_DATA;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_DATA: begin
                if (s_valid) begin
                    d.we   = 1'b1;
                    d.dout = s_data;
                    if (int'(q.cnt) == PAGE_BYTES - 1) begin
                        d.cnt = '0;
                        d.st  = S_CLOSE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            S_CLOSE: begin
                d.we   = 1'b1;
                d.cle  = 1'b1;
                d.dout = next_found ? CMD_DUMMY : CMD_PROG;
                d.cnt  = '0;
                d.st   = S_WB;
            end
            S_WB: begin
                if (int'(q.cnt) >= WB_CYC - 1) begin
                    d.cnt = '0;
                    d.st  = S_BUSY;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_BUSY: begin
                if (dev_rdy) begin
                    if (next_found) begin
                        d.cur = next_pl;
                        d.st  = S_LOAD_CMD;
                    end else begin
                        d.st  = S_ST_CMD;
                    end
                end
            end
            S_ST_CMD: begin
                d.we   = 1'b1;
                d.cle  = 1'b1;
                d.dout = CMD_MSTAT;
                d.st   = S_ST_RD;
            end
            S_ST_RD: begin
                d.re = 1'b1;
                d.st = S_ST_CAP;
            end
            S_ST_CAP: begin
                d.fail = bus_din[NPL:1];
                d.anyf = bus_din[0];
                d.done = 1'b1;
                d.st   = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q    <= d;
        end
    end

    assign bus_cle       = q.cle;
    assign bus_ale       = q.ale;
    assign bus_we        = q.we;
    assign bus_re        = q.re;
    assign bus_dout      = q.dout;
    assign done          = q.done;
    assign done_reject   = q.rej;
    assign done_fail     = q.fail;
    assign done_any_fail = q.anyf;

endmodule

// File: rtl/mp_prog_seq_chk.sv
module mp_prog_seq_chk #(
    parameter int NPL = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_ready,
    input logic           s_valid,
    input logic [7:0]     s_data,
    input logic           s_ready,
    input logic           bus_cle,
    input logic           bus_ale,
    input logic           bus_we,
    input logic           bus_re,
    input logic [7:0]     bus_dout,
    input logic           done,
    input logic           done_reject,
    input logic [NPL-1:0] done_fail,
    input logic           done_any_fail
);
    a_r1_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> !req_ready);

    a_r2_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_we && !bus_re));

    a_r2_reject_result: assert property (@(posedge clk) disable iff (!rst_n)
        done_reject |-> (done && done_fail == '0 && !done_any_fail));

    a_r4_data_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> (bus_we && !bus_cle && !bus_ale && bus_dout == $past(s_data)));

    a_r7_read_after_status_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |-> $past(bus_we && bus_cle && bus_dout == 8'h71));

    a_r8_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_reject) |-> $past(bus_re));

    a_r9_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cle || bus_ale) |-> (bus_we && !(bus_cle && bus_ale)));

    a_r9_rw_excl: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |-> !bus_we);
endmodule

bind mp_prog_seq mp_prog_seq_chk #(.NPL(NPL)) chk_i (.*);

// File: tb/mp_prog_seq_tb_top.sv
`timescale 1ns/1ps
module mp_prog_seq_tb_top;
    localparam int NPL = 4, PB = 528, BLK_W = 12, PAGE_W = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ptr_b = 1'b0, s_valid = 1'b0;
    logic [NPL-1:0] req_mask = '0;
    logic [NPL*BLK_W-1:0] req_blocks = '0;
    logic [PAGE_W-1:0] req_page = '0;
    logic [7:0] s_data = '0, bus_din = '0, bus_dout;
    logic req_ready, s_ready, bus_cle, bus_ale, bus_we, bus_re, dev_rdy;
    logic done, done_reject, done_any_fail;
    logic [NPL-1:0] done_fail;

    int checks = 0, failures = 0, cyc = 0, busy_cnt = 0;
    logic [9:0] exp_bus[$];   // {kind, byte}: 0 data, 1 cmd, 2 addr, 3 read
    logic [5:0] exp_res[$];   // {reject, fail[3:0], any}
    logic [7:0] data_q[$];

    always #2 clk = ~clk;
    assign dev_rdy = (busy_cnt == 0);

    mp_prog_seq dut_i (.*);

    function automatic string tag_of(logic [9:0] it);
        if (it[9:8] == 2'd0) return "R4";
        if (it[9:8] == 2'd2) return "R3";
        if (it[9:8] == 2'd3) return "R7";
        if (it[7:0] == 8'h11 || it[7:0] == 8'h10) return "R5";
        if (it[7:0] == 8'h71) return "R7";
        return "R3";
    endfunction

    // Monitor / scoreboard and device model, all on the falling edge.
    always @(negedge clk) begin
        if (rst_n && (bus_we || bus_re)) begin
            logic [9:0] got, want;
            got = bus_re ? {2'd3, 8'h00} : {(bus_cle ? 2'd1 : bus_ale ? 2'd2 : 2'd0), bus_dout};
            checks++;
            if (busy_cnt != 0) begin
                failures++;
                $display("FAIL R6 bus cycle while busy: got %h expected none", got);
            end else if (bus_cle && bus_ale) begin
                failures++;
                $display("FAIL R9 cle and ale both high: got 1 expected 0");
            end else if (exp_bus.size() == 0) begin
                failures++;
                $display("FAIL R2 unexpected bus item: got %h expected none", got);
            end else begin
                want = exp_bus.pop_front();
                if (got !== want) begin
                    failures++;
                    $display("FAIL %s bus item: got %h expected %h", tag_of(want), got, want);
                end
            end
        end
        if (rst_n && done) begin
            checks++;
            if (exp_res.size() == 0) begin
                failures++;
                $display("FAIL R8 unexpected done: got %b expected none", {done_reject, done_fail, done_any_fail});
            end else begin
                logic [5:0] w;
                w = exp_res.pop_front();
                if ({done_reject, done_fail, done_any_fail} !== w) begin
                    failures++;
                    $display("FAIL %s result: got %b expected %b", w[5] ? "R2" : "R8",
                             {done_reject, done_fail, done_any_fail}, w);
                end
            end
        end
        if (bus_we && bus_cle && (bus_dout == 8'h11 || bus_dout == 8'h10))
            busy_cnt = (bus_dout == 8'h11) ? 3 : 20;
        else if (busy_cnt > 0)
            busy_cnt--;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(bit ok, string msg);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic run_op(logic [3:0] mask, int b0, int b1, int b2, int b3,
                          int page, bit ptr_b, logic [3:0] fails, int seed);
        int blk[4];
        bit ok;
        int last;
        blk = '{b0, b1, b2, b3};
        ok = (mask != 0) && !ptr_b;
        last = 0;
        for (int p = 0; p < 4; p++) begin
            if (mask[p] && (blk[p] % 4) != p) ok = 0;
            if (mask[p]) last = p;
        end
        data_q.delete();
        if (ok) begin
            for (int p = 0; p < 4; p++) begin
                if (mask[p]) begin
                    logic [23:0] row;
                    row = 24'(blk[p] * 32 + page);
                    exp_bus.push_back({2'd1, 8'h80});                       // R3 load command
                    exp_bus.push_back({2'd2, 8'h00});
                    for (int b = 0; b < 3; b++) exp_bus.push_back({2'd2, row[b*8 +: 8]});
                    for (int i = 0; i < PB; i++) begin
                        logic [7:0] v;
                        v = 8'(seed + p * 37 + i * 3);
                        data_q.push_back(v);
                        exp_bus.push_back({2'd0, v});                      // R4 data order
                    end
                    exp_bus.push_back({2'd1, (p == last) ? 8'h10 : 8'h11}); // R5 close
                end
            end
            exp_bus.push_back({2'd1, 8'h71});                               // R7 status command
            exp_bus.push_back({2'd3, 8'h00});
            exp_res.push_back({1'b0, fails, |fails});                       // R8 result
            bus_din = 8'hC0 | {3'b000, fails, |fails};
        end else begin
            exp_res.push_back(6'b100000);                                   // R2 reject
        end
        @(negedge clk);
        req_valid = 1'b1; req_mask = mask; req_ptr_b = ptr_b; req_page = PAGE_W'(page);
        for (int p = 0; p < 4; p++) req_blocks[p*BLK_W +: BLK_W] = BLK_W'(blk[p]);
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        check(req_ready == ok ? 1'b0 : 1'b1,
              $sformatf("R1 req_ready after request: got %b expected %b", req_ready, !ok));
        begin
            int idx = 0;
            while (idx < data_q.size()) begin
                s_valid = ((cyc % 5) != 3);
                s_data  = data_q[idx];
                if (s_valid && s_ready) idx++;
                @(negedge clk);
            end
            s_valid = 1'b0;
        end
        while (exp_res.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_bus.size() == 0,
              $sformatf("R3 leftover bus items: got %0d expected 0", exp_bus.size()));
        check(req_ready == 1'b1 && s_ready == 1'b0,
              $sformatf("R1 idle after op: got %b%b expected 10", req_ready, s_ready));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !s_ready && !bus_we && !bus_re && !done,
              $sformatf("R1 reset state: got %b%b%b%b%b expected 10000",
                        req_ready, s_ready, bus_we, bus_re, done));
        run_op(4'b1111, 8, 13, 4094, 4095, 5, 1'b0, 4'b0000, 11);   // all planes, pass
        run_op(4'b0101, 0, 0, 2050, 0, 31, 1'b0, 4'b0100, 90);      // planes 0,2; plane 2 fails
        run_op(4'b1000, 0, 0, 0, 7, 0, 1'b0, 4'b1000, 3);           // single plane, direct 0x10
        run_op(4'b0110, 0, 1, 2, 0, 17, 1'b0, 4'b0110, 200);        // middle planes, both fail
        run_op(4'b0000, 0, 1, 2, 3, 1, 1'b0, 4'b0000, 0);           // R2 empty mask
        run_op(4'b0011, 4, 6, 0, 0, 1, 1'b0, 4'b0000, 0);           // R2 plane 1 block in plane 2
        run_op(4'b0001, 4, 0, 0, 0, 1, 1'b1, 4'b0000, 0);           // R2 pointer-B mode
        run_op(4'b0011, 4092, 4093, 0, 0, 9, 1'b0, 4'b0001, 55);    // R6 short busy between planes
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule